// File: doc/BRIEF.md
# External memory wait-state sequencer

This block sits between a CPU data-bus request port and an external parallel memory bus. For each request it decides from the 16-bit address and a control byte whether the access goes outside the chip. External accesses are assigned to a lower or an upper sector, split at a boundary chosen by a 3-bit code. The block then runs a read or write strobe sequence whose length comes from that sector's 2-bit wait field, and holds the CPU off until the sequence ends.

The CPU side is a valid/ready request channel. The requester raises `req_valid` together with `req_we`, `req_addr` and `req_wdata`. It must hold all four stable until it sees `req_ready` high at a clock edge, and that edge completes the transfer. For reads, `cpu_rdata` is valid in that same cycle. The block applies back-pressure by keeping `req_ready` low for as long as an external access or its trailing idle cycle is in progress.

The control byte is laid out as follows: bit 7 is the enable, bits 6..4 the sector boundary code, bits 3..2 the upper-sector wait field, and bits 1..0 the lower-sector wait field. The address/data multiplexing latch, the bus keeper and internal memory are outside this block.

Top module: `xmem_wait_seq`

## Requirements
- R1: An access is external only when control bit 7 is 1 and the address is at least 0x1100. Any other request gets `req_ready` high in the cycle it is presented, with `cpu_rdata` = 0 and no strobe.
- R2: Boundary code 0 sends every external address to the upper sector. Code k (1..7) makes addresses at or above k*0x2000 upper and the rest lower.
- R3: With the selected wait field n, the read or write strobe is low for 1, 2, 3 or 3 cycles for n = 00, 01, 10 or 11. `req_ready` rises in cycle 3+stretch, counting the cycle in which the request is first presented to an idle block as cycle 1.
- R4: After an access whose wait field is 11, the cycle that follows the ready cycle accepts no request: `req_ready` is low and both strobes are high. With any other field the next request is accepted at once.
- R5: A read returns the value `ext_rdata` held on the last strobe-low cycle, presented on `cpu_rdata` while `req_ready` is high.
- R6: While `ext_wr_n` is low, `ext_data_oe` is 1 and `ext_wdata` carries the request's write data. During reads `ext_data_oe` is 0.
- R7: `ext_rd_n` and `ext_wr_n` (active low) are never low in the same cycle.
- R8: The control byte is sampled when an access starts. Changing it during an access does not change that access's length.
- R9: `pin_override` follows control bit 7 at all times.
- R10: During and right after reset, both strobes are high, `ext_data_oe` is 0, and `req_ready` is low while no request is presented.
- R11: From the cycle a request is first presented until its ready cycle, `ext_addr` equals the request address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_byte | input | 8 | Enable, boundary code, upper and lower wait fields |
| req_valid | input | 1 | CPU request valid |
| req_ready | output | 1 | Request completes at this edge |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | CPU address |
| req_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data, valid with req_ready on reads |
| ext_addr | output | 16 | External address |
| ext_wdata | output | 8 | External write data |
| ext_data_oe | output | 1 | External data drive enable |
| ext_rdata | input | 8 | External read data |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| pin_override | output | 1 | External interface owns the bus pins |

## Verification
A wrong sector decision or a wrong wait mapping shows up directly as the wrong number of strobe-low cycles. It also moves the `req_ready` pulse, and both are visible within the few cycles of a single access. A lost trailing idle cycle appears on the very next request, which gets accepted one cycle too early. A read captured on the wrong strobe cycle returns a value that differs from the expected one, because the stimulus changes the external data on every strobe cycle. A control byte that is not sampled at the start of an access stretches or shortens that access as soon as the byte changes mid-access.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  localparam int LIM_W = 3;
  localparam int WS_W  = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STROBE,
    ST_RELEASE,
    ST_HOLD
  } bus_st_e;

  typedef struct packed {
    logic            en;
    logic [LIM_W-1:0] lim;
    logic [WS_W-1:0]  ws_up;
    logic [WS_W-1:0]  ws_lo;
  } xcfg_t;
endpackage

// File: rtl/xmem_sector_decode.sv
module xmem_sector_decode
  import xmem_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int EXT_BASE = 'h1100
) (
  input  logic [ADDR_W-1:0] addr,
  input  xcfg_t             cfg,
  output logic              is_ext,
  output logic              use_upper,
  output logic [WS_W-1:0]   ws_sel
);
  localparam int SECT_SHIFT = ADDR_W - LIM_W;
  localparam int NCODE      = 1 << LIM_W;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(EXT_BASE);

  logic [NCODE-1:0] at_or_above;

  // code 0: no lower sector
  assign at_or_above[0] = 1'b1;

  genvar k;
  generate
    for (k = 1; k < NCODE; k++) begin : g_lim
      localparam logic [ADDR_W-1:0] LIM_A = ADDR_W'(k) << SECT_SHIFT;
      assign at_or_above[k] = (addr >= LIM_A);
    end
  endgenerate

  assign is_ext    = cfg.en && (addr >= BASE_A);
  assign use_upper = at_or_above[cfg.lim];
  assign ws_sel    = use_upper ? cfg.ws_up : cfg.ws_lo;
endmodule

// File: rtl/xmem_wait_map.sv
module xmem_wait_map
  import xmem_pkg::*;
#(
  parameter int CNT_W = WS_W
) (
  input  logic [WS_W-1:0]  ws,
  output logic [CNT_W-1:0] stretch,
  output logic             hold_en
);
  localparam logic [WS_W-1:0] WS_TOP = '1;

  // top code reuses the longest stretch and adds a trailing idle cycle
  always_comb begin
    if (ws == WS_TOP) begin
      stretch = CNT_W'(WS_TOP - 1'b1);
      hold_en = 1'b1;
    end else begin
      stretch = CNT_W'(ws);
      hold_en = 1'b0;
    end
  end
endmodule

// File: rtl/xmem_bus_fsm.sv
module xmem_bus_fsm
  import xmem_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 2,
  parameter int MAX_STRETCH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              is_ext,
  input  logic [CNT_W-1:0]  stretch,
  input  logic              hold_en,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  output logic              ext_data_oe,
  output logic              ext_rd_n,
  output logic              ext_wr_n
);
  bus_st_e           st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              we_q;
  logic              hold_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  logic start_ext;
  assign start_ext = (st_q == ST_IDLE) && req_valid && is_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      we_q    <= 1'b0;
      hold_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_ext) begin
            st_q    <= ST_STROBE;
            cnt_q   <= stretch;
            hold_q  <= hold_en;
            we_q    <= req_we;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
          end
        end
        ST_STROBE: begin
          if (cnt_q == '0) begin
            st_q <= ST_RELEASE;
            if (!we_q) rdata_q <= ext_rdata;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_RELEASE: st_q <= hold_q ? ST_HOLD : ST_IDLE;
        ST_HOLD:    st_q <= ST_IDLE;
        default:    st_q <= ST_IDLE;
      endcase
    end
  end

  logic strobe_on;
  assign strobe_on   = (st_q == ST_STROBE);
  assign ext_rd_n    = !(strobe_on && !we_q);
  assign ext_wr_n    = !(strobe_on && we_q);
  assign ext_data_oe = strobe_on && we_q;
  assign ext_wdata   = wdata_q;
  assign ext_addr    = (st_q == ST_IDLE) ? req_addr : addr_q;
  assign req_ready   = ((st_q == ST_IDLE) && req_valid && !is_ext) || (st_q == ST_RELEASE);
  assign cpu_rdata   = ((st_q == ST_RELEASE) && !we_q) ? rdata_q : '0;

  // run length of the current strobe, for the length check
  logic [CNT_W:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_q <= '0;
    else if (strobe_on) run_q <= run_q + 1'b1;
    else                run_q <= '0;
  end

  // R3
  strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rd_n || !ext_wr_n) |-> (run_q <= (CNT_W+1)'(MAX_STRETCH)));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n));

  // R3
  strobe_end_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ext_rd_n) || $rose(ext_wr_n)) |-> req_ready);

  // R4
  hold_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RELEASE && hold_q) |=> (!req_ready && ext_rd_n && ext_wr_n));

  // R11
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STROBE || st_q == ST_RELEASE) |-> $stable(ext_addr));

  // R6
  wdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_wr_n && !$rose(ext_data_oe)) |-> $stable(ext_wdata));
endmodule

// File: rtl/xmem_wait_seq.sv
module xmem_wait_seq
  import xmem_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int EXT_BASE = 'h1100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        ctrl_byte,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  output logic              ext_data_oe,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic              ext_rd_n,
  output logic              ext_wr_n,
  output logic              pin_override
);
  localparam int CNT_W       = WS_W;
  localparam int MAX_STRETCH = (1 << WS_W) - 2;

  xcfg_t            cfg;
  logic             is_ext;
  logic             use_upper;
  logic [WS_W-1:0]  ws_sel;
  logic [CNT_W-1:0] stretch;
  logic             hold_en;

  assign cfg          = xcfg_t'(ctrl_byte);
  assign pin_override = cfg.en;

  xmem_sector_decode #(
    .ADDR_W  (ADDR_W),
    .EXT_BASE(EXT_BASE)
  ) dec_i (
    .addr     (req_addr),
    .cfg      (cfg),
    .is_ext   (is_ext),
    .use_upper(use_upper),
    .ws_sel   (ws_sel)
  );

  xmem_wait_map #(
    .CNT_W(CNT_W)
  ) map_i (
    .ws     (ws_sel),
    .stretch(stretch),
    .hold_en(hold_en)
  );

  xmem_bus_fsm #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .CNT_W      (CNT_W),
    .MAX_STRETCH(MAX_STRETCH)
  ) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_we     (req_we),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .is_ext     (is_ext),
    .stretch    (stretch),
    .hold_en    (hold_en),
    .ext_rdata  (ext_rdata),
    .req_ready  (req_ready),
    .cpu_rdata  (cpu_rdata),
    .ext_addr   (ext_addr),
    .ext_wdata  (ext_wdata),
    .ext_data_oe(ext_data_oe),
    .ext_rd_n   (ext_rd_n),
    .ext_wr_n   (ext_wr_n)
  );

  // R2
  lo_sector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ext && !use_upper) |-> (cfg.lim != '0));

  // R9
  override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_override && ext_rd_n && ext_wr_n && req_valid) |-> req_ready);
endmodule

// File: tb/xmem_wait_seq_tb_top.sv
`timescale 1ns/1ps
module xmem_wait_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ctrl_byte = 8'h00;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic [15:0] ext_addr;
  logic [7:0]  ext_wdata;
  logic        ext_data_oe;
  logic [7:0]  ext_rdata = 8'hEE;
  logic        ext_rd_n;
  logic        ext_wr_n;
  logic        pin_override;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  xmem_wait_seq dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_byte(ctrl_byte),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .cpu_rdata(cpu_rdata),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_data_oe(ext_data_oe),
    .ext_rdata(ext_rdata), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
    .pin_override(pin_override)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  // fields: we, addr, data, ctrl, expected cycles to ready, expected strobe cycles
  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [7:0]  cfg;
    logic [3:0]  cyc;
    logic [3:0]  stb;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h1100, 8'h30, 8'h88, 4'd5, 4'd3},  // code 0, upper 10
    '{1'b0, 16'h10FF, 8'h31, 8'h88, 4'd1, 4'd0},  // below window
    '{1'b0, 16'h3000, 8'h40, 8'hA6, 4'd5, 4'd3},  // code 2, lower 10
    '{1'b0, 16'h4000, 8'h41, 8'hA6, 4'd4, 4'd2},  // code 2, upper 01
    '{1'b1, 16'h1FFF, 8'h5A, 8'h91, 4'd4, 4'd2},  // code 1, lower 01
    '{1'b1, 16'h2000, 8'hA5, 8'h91, 4'd3, 4'd1},  // code 1, upper 00
    '{1'b0, 16'hFFFF, 8'h60, 8'hFC, 4'd5, 4'd3},  // code 7, upper 11
    '{1'b0, 16'hDFFF, 8'h61, 8'hFC, 4'd3, 4'd1},  // code 7, lower 00
    '{1'b0, 16'h8000, 8'h70, 8'h08, 4'd1, 4'd0},  // disabled
    '{1'b1, 16'h0000, 8'h71, 8'h88, 4'd1, 4'd0},  // internal write
    '{1'b1, 16'hA000, 8'hC3, 8'hD3, 4'd3, 4'd1},  // code 5, upper 00
    '{1'b0, 16'h9FFF, 8'h80, 8'hD3, 4'd5, 4'd3}   // code 5, lower 11
  };

  task automatic run_access(input logic we, input logic [15:0] addr, input logic [7:0] data,
                            input logic [7:0] cfg, input logic [7:0] cfg_mid,
                            input int exp_cyc, input int exp_stb);
    int cyc = 0;
    int stb = 0;
    bit got = 1'b0;
    logic [7:0] rd = '0;
    @(posedge clk); #1;
    ctrl_byte = cfg; req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = data;
    while (!got && cyc < 20) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) chk(pin_override == cfg[7], "R9 pin_override", pin_override, cfg[7]);
      chk(!( !ext_rd_n && !ext_wr_n), "R7 both strobes low", {ext_rd_n, ext_wr_n}, 3);
      if (exp_stb > 0) chk(ext_addr == addr, "R11 ext_addr", ext_addr, addr);
      if (!ext_wr_n) begin
        stb++;
        chk(ext_data_oe && ext_wdata == data, "R6 write data drive", {ext_data_oe, ext_wdata}, {1'b1, data});
      end else if (!ext_rd_n) begin
        stb++;
        chk(!ext_data_oe, "R6 oe during read", ext_data_oe, 0);
        ext_rdata = data + 8'(stb);
      end
      if (cyc == 2) ctrl_byte = cfg_mid;
      if (req_ready) begin
        got = 1'b1;
        rd = cpu_rdata;
      end
    end
    chk(got && cyc == exp_cyc, "R3/R1 cycles to ready", cyc, exp_cyc);
    chk(stb == exp_stb, "R2/R3 strobe cycles", stb, exp_stb);
    if (!we)
      chk(rd == ((exp_stb > 0) ? data + 8'(exp_stb) : 8'h00), "R5/R1 read data",
          rd, (exp_stb > 0) ? data + 8'(exp_stb) : 0);
    @(posedge clk); #1;
    req_valid = 1'b0;
    ext_rdata = 8'hEE;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    chk(ext_rd_n && ext_wr_n && !ext_data_oe && !req_ready, "R10 in reset",
        {ext_rd_n, ext_wr_n, ext_data_oe, req_ready}, 4'b1100);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(ext_rd_n && ext_wr_n && !ext_data_oe && !req_ready, "R10 after reset",
        {ext_rd_n, ext_wr_n, ext_data_oe, req_ready}, 4'b1100);

    // R9 direct
    ctrl_byte = 8'h80; #1;
    chk(pin_override == 1'b1, "R9 override on", pin_override, 1);
    ctrl_byte = 8'h7F; #1;
    chk(pin_override == 1'b0, "R9 override off", pin_override, 0);

    for (int i = 0; i < NV; i++)
      run_access(VECS[i].we, VECS[i].addr, VECS[i].data, VECS[i].cfg, VECS[i].cfg,
                 int'(VECS[i].cyc), int'(VECS[i].stb));

    // R8: wait field shrinks mid-access, length must not change
    run_access(1'b0, 16'h2000, 8'h12, 8'h88, 8'h80, 5, 3);
    // R8: wait field grows mid-access
    run_access(1'b0, 16'h2000, 8'h13, 8'h80, 8'h88, 3, 1);

    // R4: trailing idle cycle after code 11
    run_access(1'b0, 16'hF000, 8'h20, 8'hFC, 8'hFC, 5, 3);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 16'h0100;
    @(negedge clk);
    chk(!req_ready && ext_rd_n && ext_wr_n, "R4 idle gap blocks request",
        {req_ready, ext_rd_n, ext_wr_n}, 3'b011);
    @(negedge clk);
    chk(req_ready, "R4 request accepted after gap", req_ready, 1);
    @(posedge clk); #1 req_valid = 1'b0;

    // R4: no gap for other codes
    run_access(1'b0, 16'hF000, 8'h21, 8'hF0, 8'hF0, 3, 1);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 16'h0100;
    @(negedge clk);
    chk(req_ready, "R4 no gap for code 00", req_ready, 1);
    @(posedge clk); #1 req_valid = 1'b0;

    // R1: lowest external address with enable off stays internal
    run_access(1'b1, 16'h1100, 8'h77, 8'h08, 8'h08, 1, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule